// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a watchdog with a small register interface. Software arms it, opens its configuration and refreshes it only by writing special values to a key register. Once armed, a down-counter is decremented on every tick of a programmable prescaler. If software stops refreshing it, the counter runs out and the block emits a single-cycle reset pulse, then starts a new period.

The prescaler code and the reload value are write-protected. They accept writes only while the configuration is unlocked. An accepted write is held in a shadow register and is copied into the active setting a fixed number of cycles later. While that copy is pending, a busy flag in the status register stays set. Software polls the status register for zero before it refreshes, so that the counter starts from the new settings.

A software-driven forced reset works as follows: set the reload to 1, wait for status to clear, then refresh. The pulse follows after one prescaler period.

Top module: `keyed_wdog`

## Requirements
- R1: After reset the block is stopped (`wdRunning`=0, `wdReset`=0), reads return reload 0xFFF at address 2, prescaler code 0 at address 1, and status 0 at address 3.
- R2: Writing 0xCCCC to the key register (address 0) starts the watchdog and loads the counter from the active reload. No write can stop it afterwards.
- R3: Writing 0xCCCC while the watchdog is already running has no effect on the counter, so the pending expiry keeps its original cycle.
- R4: Writing 0x5555 to the key register unlocks the configuration. While locked, writes to the prescaler (address 1, bits 2:0) or reload (address 2, bits 11:0) are ignored: status stays 0 and the readback does not change.
- R5: Any key write other than 0x5555 locks the configuration again. Writes to the configuration registers themselves do not change the lock.
- R6: An accepted configuration write sets its busy bit (status bit 0 for the prescaler, bit 1 for the reload) for exactly BUSY_CYCLES cycles. The new value then becomes active and readable.
- R7: Writing 0xAAAA to the key register reloads the counter and restarts the prescaler phase. No reset pulse appears in the cycle after that write.
- R8: Prescaler code n divides by 4·2^n. With reload R ≥ 1, the pulse appears R·4·2^n cycles after the refresh or start write.
- R9: At expiry, `wdReset` is high for exactly one cycle and the counter reloads, so pulses repeat every R·4·2^n cycles until a refresh.
- R10: With reload 1 and code 1, a refresh produces a pulse 8 cycles later (forced reset).
- R11: While the watchdog is stopped, no reset pulse is produced, even after a refresh key.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Write address: 0 key, 1 prescaler, 2 reload |
| wrData | input | DATA_W | Write data |
| rdAddr | input | 2 | Read address: 1 prescaler, 2 reload, 3 status |
| rdData | output | DATA_W | Combinational read data |
| wdRunning | output | 1 | Watchdog has been started |
| wdReset | output | 1 | One-cycle system reset pulse |

## Verification
The bound checker watches the properties that hold on every cycle:
- the pulse lasts one cycle, and no pulse is produced while stopped;
- the run state is sticky, and every non-unlock key relocks;
- locked writes never raise a busy flag, and busy flags rise only after a matching write;
- no pulse follows a refresh.

The exact expiry cycle for each divider and reload, the periodic repeat, the busy-window length, and the ignored second start can only be shown by the bench's scenarios. These compare each observed pulse against a predicted cycle.

// File: rtl/kwd_pkg.sv
package kwd_pkg;
  localparam logic [15:0] KEY_START   = 16'hCCCC;
  localparam logic [15:0] KEY_UNLOCK  = 16'h5555;
  localparam logic [15:0] KEY_REFRESH = 16'hAAAA;

  localparam logic [1:0] ADDR_KEY  = 2'd0;
  localparam logic [1:0] ADDR_PRE  = 2'd1;
  localparam logic [1:0] ADDR_RLD  = 2'd2;
  localparam logic [1:0] ADDR_STAT = 2'd3;

  // log2 of the smallest divider (code 0 divides by 4)
  localparam int DIV_BASE_LOG2 = 2;

  typedef struct packed {
    logic run;   // counter may advance
    logic load;  // reload counter and restart prescaler phase
  } wdStrobe_t;
endpackage

// File: rtl/kwd_cfg_shadow.sv
module kwd_cfg_shadow #(
  parameter int W = 12,
  parameter int CYCLES = 4,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wrStb,
  input  logic [W-1:0] wrVal,
  output logic         busy,
  output logic [W-1:0] active
);
  localparam int CNT_W = $clog2(CYCLES + 1);

  logic [W-1:0]     pendVal;
  logic [CNT_W-1:0] busyCnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pendVal <= RST_VAL;
      active  <= RST_VAL;
      busy    <= 1'b0;
      busyCnt <= '0;
    end else if (wrStb) begin
      // a new write restarts the transfer window
      pendVal <= wrVal;
      busy    <= 1'b1;
      busyCnt <= CNT_W'(CYCLES);
    end else if (busy) begin
      if (busyCnt == CNT_W'(1)) begin
        busy   <= 1'b0;
        active <= pendVal;
      end else begin
        busyCnt <= busyCnt - CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/kwd_ctrl.sv
module kwd_ctrl
  import kwd_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CODE_W = 3,
  parameter int RELOAD_W = 12,
  parameter int BUSY_CYCLES = 4,
  parameter logic [RELOAD_W-1:0] RELOAD_RST = '1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wrEn,
  input  logic [1:0]          wrAddr,
  input  logic [DATA_W-1:0]   wrData,
  output wdStrobe_t           strobe,
  output logic [CODE_W-1:0]   activeCode,
  output logic [RELOAD_W-1:0] activeReload,
  output logic                preBusy,
  output logic                rlBusy,
  output logic                unlocked
);
  logic running;
  logic keyWr, isStart, isUnlock, isRefresh;
  logic preWr, rldWr;

  assign keyWr     = wrEn && (wrAddr == ADDR_KEY);
  assign isStart   = keyWr && (wrData == DATA_W'(KEY_START));
  assign isUnlock  = keyWr && (wrData == DATA_W'(KEY_UNLOCK));
  assign isRefresh = keyWr && (wrData == DATA_W'(KEY_REFRESH));
  assign preWr     = wrEn && unlocked && (wrAddr == ADDR_PRE);
  assign rldWr     = wrEn && unlocked && (wrAddr == ADDR_RLD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running  <= 1'b0;
      unlocked <= 1'b0;
    end else begin
      if (isStart) running <= 1'b1;
      if (keyWr) unlocked <= isUnlock;
    end
  end

  always_comb begin
    strobe.run  = running;
    strobe.load = isRefresh || (isStart && !running);
  end

  kwd_cfg_shadow #(
    .W(CODE_W), .CYCLES(BUSY_CYCLES), .RST_VAL('0)
  ) u_preShadow (
    .clk(clk), .rst_n(rst_n), .wrStb(preWr),
    .wrVal(wrData[CODE_W-1:0]), .busy(preBusy), .active(activeCode)
  );

  kwd_cfg_shadow #(
    .W(RELOAD_W), .CYCLES(BUSY_CYCLES), .RST_VAL(RELOAD_RST)
  ) u_rldShadow (
    .clk(clk), .rst_n(rst_n), .wrStb(rldWr),
    .wrVal(wrData[RELOAD_W-1:0]), .busy(rlBusy), .active(activeReload)
  );
endmodule

// File: rtl/kwd_datapath.sv
module kwd_datapath
  import kwd_pkg::*;
#(
  parameter int CODE_W = 3,
  parameter int RELOAD_W = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  wdStrobe_t           strobe,
  input  logic [CODE_W-1:0]   activeCode,
  input  logic [RELOAD_W-1:0] activeReload,
  output logic                wdReset
);
  localparam int DIV_W = DIV_BASE_LOG2 + (1 << CODE_W);

  logic [DIV_W-1:0]    divCnt;
  logic [DIV_W-1:0]    divLimit;
  logic [RELOAD_W-1:0] count;
  logic                tick;

  assign divLimit = (DIV_W'(1) << (activeCode + DIV_BASE_LOG2)) - DIV_W'(1);
  // ">=" covers a divider that shrinks mid-period
  assign tick = strobe.run && (divCnt >= divLimit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      divCnt  <= '0;
      count   <= '0;
      wdReset <= 1'b0;
    end else begin
      wdReset <= 1'b0;
      if (strobe.load) begin
        divCnt <= '0;
        count  <= activeReload;
      end else if (tick) begin
        divCnt <= '0;
        if (count <= RELOAD_W'(1)) begin
          wdReset <= 1'b1;
          count   <= activeReload;
        end else begin
          count <= count - RELOAD_W'(1);
        end
      end else if (strobe.run) begin
        divCnt <= divCnt + DIV_W'(1);
      end
    end
  end
endmodule

// File: rtl/keyed_wdog.sv
module keyed_wdog
  import kwd_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CODE_W = 3,
  parameter int RELOAD_W = 12,
  parameter int BUSY_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic [1:0]        wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [1:0]        rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              wdRunning,
  output logic              wdReset
);
  wdStrobe_t           strobe;
  logic [CODE_W-1:0]   activeCode;
  logic [RELOAD_W-1:0] activeReload;
  logic                preBusy, rlBusy, isUnlocked;

  kwd_ctrl #(
    .DATA_W(DATA_W), .CODE_W(CODE_W), .RELOAD_W(RELOAD_W),
    .BUSY_CYCLES(BUSY_CYCLES), .RELOAD_RST('1)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .strobe(strobe), .activeCode(activeCode), .activeReload(activeReload),
    .preBusy(preBusy), .rlBusy(rlBusy), .unlocked(isUnlocked)
  );

  kwd_datapath #(
    .CODE_W(CODE_W), .RELOAD_W(RELOAD_W)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe),
    .activeCode(activeCode), .activeReload(activeReload), .wdReset(wdReset)
  );

  assign wdRunning = strobe.run;

  always_comb begin
    case (rdAddr)
      ADDR_PRE:  rdData = DATA_W'(activeCode);
      ADDR_RLD:  rdData = DATA_W'(activeReload);
      ADDR_STAT: rdData = DATA_W'({rlBusy, preBusy});
      default:   rdData = '0;
    endcase
  end
endmodule

// File: rtl/kwd_chk.sv
module kwd_chk
  import kwd_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wrEn,
  input logic [1:0]        wrAddr,
  input logic [DATA_W-1:0] wrData,
  input logic              wdRunning,
  input logic              wdReset,
  input logic              preBusy,
  input logic              isUnlocked
);
  // R9
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wdReset |=> !wdReset);

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wdRunning |-> !wdReset);

  // R2
  run_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wdRunning |=> wdRunning);

  // R5
  relock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && wrAddr == ADDR_KEY && wrData != DATA_W'(KEY_UNLOCK)) |=> !isUnlocked);

  // R4
  locked_pre_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && wrAddr == ADDR_PRE && !isUnlocked && !preBusy) |=> !preBusy);

  // R6
  busy_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(preBusy) |-> $past(wrEn && wrAddr == ADDR_PRE));

  // R7
  load_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && wrAddr == ADDR_KEY && wrData == DATA_W'(KEY_REFRESH)) |=> !wdReset);
endmodule

bind keyed_wdog kwd_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
  .wdRunning(wdRunning), .wdReset(wdReset), .preBusy(preBusy),
  .isUnlocked(isUnlocked)
);

// File: tb/keyed_wdog_tb.sv
module keyed_wdog_tb;
  localparam int BUSY = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrAddr = '0;
  logic [15:0] wrData = '0;
  logic [1:0]  rdAddr = '0;
  logic [15:0] rdData;
  logic        wdRunning, wdReset;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int lastCyc = 0;
  int pulseSeen = 0;
  bit ignorePulses = 1'b0;
  bit finished = 1'b0;
  int expCyc[$];
  string expTag[$];

  always #2.5 clk = ~clk;  // 200 MHz

  keyed_wdog #(.BUSY_CYCLES(BUSY)) u_dut (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .wdRunning(wdRunning), .wdReset(wdReset)
  );

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // monitor: compare each pulse with the next predicted cycle
  always @(negedge clk) begin
    if (rst_n && wdReset) begin
      pulseSeen++;
      if (!ignorePulses) begin
        if (expCyc.size() == 0) begin
          chk(1'b0, "R9", "unexpected pulse at cycle", cyc, -1);
        end else begin
          automatic int e = expCyc.pop_front();
          automatic string t = expTag.pop_front();
          chk(cyc == e, t, "pulse cycle", cyc, e);
        end
      end
    end
  end

  task automatic expect_pulse(input int at, input string tag);
    expCyc.push_back(at);
    expTag.push_back(tag);
  endtask

  // all bus tasks start and end at a falling edge
  task automatic bus_write(input logic [1:0] a, input logic [15:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(posedge clk);
    @(negedge clk);
    wrEn = 1'b0;
    lastCyc = cyc;
  endtask

  task automatic read_check(input logic [1:0] a, input int exp,
                            input string req, input string what);
    rdAddr = a;
    #1;
    chk(int'(rdData) == exp, req, what, int'(rdData), exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_until(input int target);
    while (cyc < target) @(negedge clk);
  endtask

  task automatic refresh_and_track;
    bus_write(2'd0, 16'hAAAA);
    expCyc.delete();
    expTag.delete();
    ignorePulses = 1'b0;
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "R1", "watchdog expired", cyc, 0);
    finish_run();
  end

  initial begin
    int c0;
    int c1;
    int c2;
    int c3;
    int c4;
    int c5;
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state
    chk(wdRunning == 1'b0, "R1", "running after reset", wdRunning, 0);
    chk(wdReset == 1'b0, "R1", "pulse after reset", wdReset, 0);
    read_check(2'd2, 12'hFFF, "R1", "reload reset");
    read_check(2'd1, 0, "R1", "prescaler reset");
    read_check(2'd3, 0, "R1", "status reset");

    // R4 locked write ignored
    bus_write(2'd1, 16'd3);
    read_check(2'd3, 0, "R4", "status after locked write");
    idle(BUSY + 1);
    read_check(2'd1, 0, "R4", "prescaler after locked write");

    // R11 refresh while stopped: no pulse
    bus_write(2'd0, 16'hAAAA);
    idle(100);
    chk(pulseSeen == 0, "R11", "pulses while stopped", pulseSeen, 0);
    chk(wdRunning == 1'b0, "R11", "running while stopped", wdRunning, 0);

    // R6 busy window on prescaler write
    bus_write(2'd0, 16'h5555);
    bus_write(2'd1, 16'd1);
    read_check(2'd3, 1, "R6", "prescaler busy right after write");
    idle(BUSY - 1);
    read_check(2'd3, 1, "R6", "prescaler busy at last cycle");
    idle(1);
    read_check(2'd3, 0, "R6", "prescaler busy cleared");
    read_check(2'd1, 1, "R6", "prescaler transferred");

    // register writes keep the lock open; reload write accepted
    bus_write(2'd2, 16'd3);
    read_check(2'd3, 2, "R6", "reload busy bit");
    idle(BUSY + 1);
    read_check(2'd2, 3, "R5", "reload accepted while unlocked");

    // R5 other key relocks
    bus_write(2'd0, 16'h1234);
    bus_write(2'd2, 16'd7);
    read_check(2'd3, 0, "R5", "status after relock write");
    idle(BUSY + 1);
    read_check(2'd2, 3, "R5", "reload unchanged after relock");

    // R2 start: reload 3, divide 8 -> 24 cycles
    bus_write(2'd0, 16'hCCCC);
    c0 = lastCyc;
    chk(wdRunning == 1'b1, "R2", "running after start", wdRunning, 1);
    expect_pulse(c0 + 24, "R2");
    expect_pulse(c0 + 48, "R9");
    idle(9);
    // R3 second start ignored
    bus_write(2'd0, 16'hCCCC);
    wait_until(c0 + 50);
    chk(expCyc.size() == 0, "R3", "pending pulses after restart", expCyc.size(), 0);

    // R7 refresh reloads counter
    refresh_and_track();
    c1 = lastCyc;
    expect_pulse(c1 + 24, "R7");
    idle(10);
    refresh_and_track();
    c2 = lastCyc;
    expect_pulse(c2 + 24, "R7");
    expect_pulse(c2 + 48, "R9");
    wait_until(c2 + 50);
    chk(expCyc.size() == 0, "R9", "periodic pulses outstanding", expCyc.size(), 0);

    // R10 forced reset: reload 1, divide 8
    ignorePulses = 1'b1;
    bus_write(2'd0, 16'h5555);
    bus_write(2'd2, 16'd1);
    idle(BUSY + 1);
    read_check(2'd3, 0, "R10", "status before forced refresh");
    refresh_and_track();
    c3 = lastCyc;
    expect_pulse(c3 + 8, "R10");
    wait_until(c3 + 9);
    chk(expCyc.size() == 0, "R10", "forced pulse outstanding", expCyc.size(), 0);

    // R8 largest divider: code 7, reload 2 -> 1024 cycles
    ignorePulses = 1'b1;
    bus_write(2'd0, 16'h5555);
    bus_write(2'd1, 16'd7);
    bus_write(2'd2, 16'd2);
    idle(BUSY + 1);
    read_check(2'd1, 7, "R8", "prescaler code 7");
    refresh_and_track();
    c4 = lastCyc;
    expect_pulse(c4 + 1024, "R8");
    expect_pulse(c4 + 2048, "R9");
    wait_until(c4 + 2050);

    // R8 smallest divider: code 0, reload 5 -> 20 cycles
    ignorePulses = 1'b1;
    bus_write(2'd0, 16'h5555);
    bus_write(2'd1, 16'd0);
    bus_write(2'd2, 16'd5);
    idle(BUSY + 1);
    refresh_and_track();
    c5 = lastCyc;
    expect_pulse(c5 + 20, "R8");
    expect_pulse(c5 + 40, "R9");
    wait_until(c5 + 42);
    chk(expCyc.size() == 0, "R8", "pulses outstanding at end", expCyc.size(), 0);
    chk(wdRunning == 1'b1, "R2", "still running at end", wdRunning, 1);

    finish_run();
  end
endmodule